// File: doc/BRIEF.md
# Accumulator ALU with Condition-Code Update

This block is the purely combinational arithmetic and logic stage of a small dual-accumulator processor. An operation code selects one of twenty-one data operations. Operand `a_i` is always an accumulator. Operand `m_i` is a memory byte or the second accumulator. The incoming condition-code byte is also an input. In the same cycle the block returns the result byte, a flag saying whether that result should be written back, and the new condition-code byte.

Each operation class touches only its own set of flags and forces some flags to fixed values. The interrupt-mask bit is never changed. Half carry is updated by the plain and carried additions only. Single-operand operations act on `m_i`, so the sequencer routes an accumulator there when it wants an accumulator form. Sequencing, memory access, sixteen-bit operations and decimal adjust belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) gives A+M and opcode 1 (add with carry) gives A+M+C. C is the carry out of bit 7, H is the carry out of bit 3, and V is two's-complement overflow.
- R2: Opcode 2 (subtract) gives A−M, opcode 3 gives A−M−C and opcode 4 (compare) computes A−M without write-back. C is the borrow out of bit 7, V is signed overflow, and H is unchanged.
- R3: Opcodes 5 (AND), 6 (bit test, no write-back), 7 (XOR), 8 (OR) and 9 (load/transfer, result M) update N and Z, clear V, and leave C and H unchanged. For every defined opcode, N is result bit 7 and Z is set exactly when the result is zero.
- R4: Opcode 10 (clear) gives result 0 with N=0, Z=1, V=0 and C=0.
- R5: Opcode 11 (complement) gives the bitwise inverse of M, clears V and sets C.
- R6: Opcode 15 (test) does not write back. It reports N and Z of M and clears V and C.
- R7: Opcode 12 (negate) gives 0−M. C is set when M is nonzero and V is set only when M is 0x80.
- R8: Opcode 13 (increment) gives M+1 and sets V only for M=0x7F. Opcode 14 (decrement) gives M−1 and sets V only for M=0x80. Both leave C unchanged.
- R9: Opcode 16 shifts M left, opcode 17 shifts it right keeping bit 7, and opcode 18 shifts it right inserting 0 (so N=0). C receives the bit shifted out, and V equals N XOR the new C.
- R10: Opcode 19 rotates M left through C and opcode 20 rotates it right through C. C receives the bit shifted out and V equals N XOR the new C.
- R11: The condition-code byte is laid out as [5]=H, [4]=I, [3]=N, [2]=Z, [1]=V, [0]=C. I always passes through, and H changes only under opcodes 0 and 1.
- R12: Write-back is asserted for every defined opcode except 4, 6 and 15. Opcodes 21–31 are undefined: write-back is low, the condition-code byte passes unchanged and the result equals A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator operand |
| m_i | input | 8 | Memory or second-accumulator operand |
| ccr_i | input | 6 | Current condition codes {H,I,N,Z,V,C} |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| ccr_o | output | 6 | Updated condition codes {H,I,N,Z,V,C} |

## Verification
The hardest cases to reach are the single-value overflow corners: increment of 0x7F, decrement and negate of 0x80, and carried subtraction where the incoming borrow alone tips the result across zero or across the signed limit. They occur only when an exact operand meets an exact incoming C. The stimulus therefore sweeps every accumulator value against a fixed list of boundary operands (0x00, 0x01, 0x0F, 0x10, 0x7F, 0x80, 0x81, 0xFF and several patterns), for all 32 codes. The incoming condition byte is varied arithmetically along the sweep, so each corner is met with C both clear and set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBC = 5'd3,
    OP_CMP = 5'd4,
    OP_AND = 5'd5,
    OP_BIT = 5'd6,
    OP_EOR = 5'd7,
    OP_ORA = 5'd8,
    OP_LD  = 5'd9,
    OP_CLR = 5'd10,
    OP_COM = 5'd11,
    OP_NEG = 5'd12,
    OP_INC = 5'd13,
    OP_DEC = 5'd14,
    OP_TST = 5'd15,
    OP_ASL = 5'd16,
    OP_ASR = 5'd17,
    OP_LSR = 5'd18,
    OP_ROL = 5'd19,
    OP_ROR = 5'd20
  } alu_op_e;

  // condition-code bit positions
  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;
  localparam int CC_I = 4;
  localparam int CC_H = 5;
  localparam int CC_W = 6;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] m,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             h_out,
  output logic             v_out,
  output logic             c_out
);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  // full-width sum with carry in, carry out in the top bit
  function automatic logic [WIDTH:0] sum_ext(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic ci);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  // carry out of the lower half
  function automatic logic half_carry(input logic [WIDTH-1:0] x,
                                      input logic [WIDTH-1:0] y,
                                      input logic ci);
    logic [HALF:0] lo;
    lo = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, ci};
    return lo[HALF];
  endfunction

  logic [WIDTH-1:0] x_op, y_op, y_eff;
  logic             carry_in, borrow_in, is_sub, c_eff;
  logic [WIDTH:0]   sum;

  always_comb begin
    x_op      = a;
    y_op      = m;
    carry_in  = 1'b0;
    borrow_in = 1'b0;
    is_sub    = 1'b0;
    case (op)
      OP_ADD: ;
      OP_ADC: carry_in = cin;
      OP_SUB, OP_CMP: is_sub = 1'b1;
      OP_SBC: begin is_sub = 1'b1; borrow_in = cin; end
      OP_NEG: begin is_sub = 1'b1; x_op = '0; end
      OP_INC: begin x_op = m; y_op = WIDTH'(1); end
      OP_DEC: begin is_sub = 1'b1; x_op = m; y_op = WIDTH'(1); end
      default: ;
    endcase
  end

  // subtraction as x + ~y + ~borrow
  assign y_eff = is_sub ? ~y_op : y_op;
  assign c_eff = is_sub ? ~borrow_in : carry_in;
  assign sum   = sum_ext(x_op, y_eff, c_eff);

  assign res   = sum[WIDTH-1:0];
  assign c_out = is_sub ? ~sum[WIDTH] : sum[WIDTH];
  assign h_out = half_carry(x_op, y_eff, c_eff);
  assign v_out = (x_op[MSB] == y_eff[MSB]) && (sum[MSB] != x_op[MSB]);

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] m,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_BIT: res = a & m;
      OP_EOR:         res = a ^ m;
      OP_ORA:         res = a | m;
      OP_CLR:         res = '0;
      OP_COM:         res = ~m;
      default:        res = m;   // load, transfer, test
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] m,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             c_out
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    case (op)
      OP_ASL: {c_out, res} = {m, 1'b0};
      OP_ROL: {c_out, res} = {m, cin};
      OP_ASR: begin res = {m[MSB], m[MSB:1]}; c_out = m[0]; end
      OP_LSR: begin res = {1'b0, m[MSB:1]};   c_out = m[0]; end
      OP_ROR: begin res = {cin, m[MSB:1]};    c_out = m[0]; end
      default: begin res = m; c_out = cin; end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [4:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic [CC_W-1:0]  ccr_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wr_en_o,
  output logic [CC_W-1:0]  ccr_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op_q;
  assign op_q = alu_op_e'(op_i);

  logic [WIDTH-1:0] as_res, lg_res, sh_res;
  logic             as_h, as_v, as_c, sh_c;

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op(op_q), .a(a_i), .m(m_i), .cin(ccr_i[CC_C]),
    .res(as_res), .h_out(as_h), .v_out(as_v), .c_out(as_c)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op_q), .a(a_i), .m(m_i), .res(lg_res)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op_q), .m(m_i), .cin(ccr_i[CC_C]), .res(sh_res), .c_out(sh_c)
  );

  // named decode events, used by the checker
  logic op_valid, upd_h, keep_c, is_shift, wr_en;
  logic [WIDTH-1:0] res;
  logic h_n, v_n, c_n;

  always_comb begin
    op_valid = 1'b1;
    upd_h    = 1'b0;
    keep_c   = 1'b0;
    is_shift = 1'b0;
    wr_en    = 1'b1;
    res      = a_i;
    h_n      = ccr_i[CC_H];
    v_n      = ccr_i[CC_V];
    c_n      = ccr_i[CC_C];
    case (op_q)
      OP_ADD, OP_ADC: begin
        res = as_res; h_n = as_h; v_n = as_v; c_n = as_c; upd_h = 1'b1;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        res = as_res; v_n = as_v; c_n = as_c;
      end
      OP_CMP: begin
        res = as_res; v_n = as_v; c_n = as_c; wr_en = 1'b0;
      end
      OP_INC, OP_DEC: begin
        res = as_res; v_n = as_v; keep_c = 1'b1;
      end
      OP_AND, OP_EOR, OP_ORA, OP_LD: begin
        res = lg_res; v_n = 1'b0; keep_c = 1'b1;
      end
      OP_BIT: begin
        res = lg_res; v_n = 1'b0; keep_c = 1'b1; wr_en = 1'b0;
      end
      OP_CLR: begin
        res = lg_res; v_n = 1'b0; c_n = 1'b0;
      end
      OP_TST: begin
        res = lg_res; v_n = 1'b0; c_n = 1'b0; wr_en = 1'b0;
      end
      OP_COM: begin
        res = lg_res; v_n = 1'b0; c_n = 1'b1;
      end
      OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
        res = sh_res; c_n = sh_c; v_n = sh_res[MSB] ^ sh_c; is_shift = 1'b1;
      end
      default: begin
        op_valid = 1'b0; wr_en = 1'b0;
      end
    endcase
  end

  assign res_o   = res;
  assign wr_en_o = wr_en;
  assign ccr_o   = op_valid ? {h_n, ccr_i[CC_I], res[MSB], (res == '0), v_n, c_n}
                            : ccr_i;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [4:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             wr_en_o,
  input logic [CC_W-1:0]  ccr_i,
  input logic [CC_W-1:0]  ccr_o,
  input logic             op_valid,
  input logic             upd_h,
  input logic             keep_c,
  input logic             is_shift
);
  always_comb begin
    if (op_i == OP_CLR)
      assert_clr_flags_R4: assert (res_o == '0 && ccr_o[3:0] == 4'b0100);
    assert_imask_pass_R11: assert (ccr_o[CC_I] == ccr_i[CC_I]);
    if (!upd_h)
      assert_half_hold_R11: assert (ccr_o[CC_H] == ccr_i[CC_H]);
    if (!op_valid)
      assert_undef_quiet_R12: assert (!wr_en_o && ccr_o == ccr_i);
    if (op_valid)
      assert_zero_flag_R3: assert (ccr_o[CC_Z] == (res_o == '0));
    if (is_shift)
      assert_shift_v_R9: assert (ccr_o[CC_V] == (ccr_o[CC_N] ^ ccr_o[CC_C]));
    if (keep_c)
      assert_carry_keep_R8: assert (ccr_o[CC_C] == ccr_i[CC_C]);
  end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_i(op_i), .res_o(res_o), .wr_en_o(wr_en_o), .ccr_i(ccr_i), .ccr_o(ccr_o),
  .op_valid(op_valid), .upd_h(upd_h), .keep_c(keep_c), .is_shift(is_shift)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [4:0] op;
  logic [7:0] a, m, res;
  logic [5:0] ccr_in, ccr_out;
  logic       wr;

  alu8_core u_dut (
    .op_i(op), .a_i(a), .m_i(m), .ccr_i(ccr_in),
    .res_o(res), .wr_en_o(wr), .ccr_o(ccr_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic string tag_of(input int o);
    case (o)
      0, 1:          return "R1";
      2, 3, 4:       return "R2";
      5,6,7,8,9:     return "R3";
      10:            return "R4";
      11:            return "R5";
      12:            return "R7";
      13, 14:        return "R8";
      15:            return "R6";
      16, 17, 18:    return "R9";
      19, 20:        return "R10";
      default:       return "R12";
    endcase
  endfunction

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // reference: returns {wr, ccr[5:0], res[7:0]}
  function automatic logic [14:0] model(input int o, input int av, input int mv,
                                        input logic [5:0] cc);
    int r, t, s;
    logic h, n, z, v, c, w;
    h = cc[5]; v = cc[1]; c = cc[0]; w = 1'b1; r = 0;
    case (o)
      0, 1: begin
        t = av + mv + ((o == 1) ? int'(c) : 0);
        h = ((av % 16) + (mv % 16) + ((o == 1) ? int'(c) : 0)) > 15;
        s = sgn(av) + sgn(mv) + ((o == 1) ? int'(c) : 0);
        r = t % 256; c = t > 255; v = (s > 127) || (s < -128);
      end
      2, 3, 4: begin
        t = av - mv - ((o == 3) ? int'(c) : 0);
        s = sgn(av) - sgn(mv) - ((o == 3) ? int'(c) : 0);
        r = (t + 512) % 256; c = t < 0; v = (s > 127) || (s < -128);
        w = (o != 4);
      end
      5, 6: begin r = av & mv; v = 0; w = (o != 6); end
      7:  begin r = av ^ mv; v = 0; end
      8:  begin r = av | mv; v = 0; end
      9:  begin r = mv; v = 0; end
      10: begin r = 0; v = 0; c = 0; end
      11: begin r = 255 - mv; v = 0; c = 1; end
      12: begin r = (256 - mv) % 256; c = (mv != 0); v = (mv == 128); end
      13: begin r = (mv + 1) % 256; v = (mv == 127); end
      14: begin r = (mv + 255) % 256; v = (mv == 128); end
      15: begin r = mv; v = 0; c = 0; w = 0; end
      16: begin r = (mv * 2) % 256; c = (mv >= 128); end
      17: begin r = (mv / 2) + (mv & 128); c = mv % 2; end
      18: begin r = mv / 2; c = mv % 2; end
      19: begin r = (mv * 2) % 256 + int'(c); c = (mv >= 128); end
      20: begin r = (mv / 2) + 128 * int'(c); c = mv % 2; end
      default: return {1'b0, cc, 8'(av)};
    endcase
    n = (r >= 128);
    z = (r == 0);
    if (o >= 16 && o <= 20) v = n ^ c;
    return {w, h, cc[4], n, z, v, c, 8'(r)};
  endfunction

  task automatic apply_check(input int o, input int av, input int mv,
                             input logic [5:0] cc);
    logic [14:0] exp_v;
    @(posedge clk);
    #1;
    op = 5'(o); a = 8'(av); m = 8'(mv); ccr_in = cc;
    #1;
    exp_v = model(o, av, mv, cc);
    checks++;
    if ({wr, ccr_out, res} !== exp_v) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h m=%02h ccr=%02h: got wr=%0b ccr=%02h res=%02h, expected wr=%0b ccr=%02h res=%02h",
               tag_of(o), o, av, mv, cc, wr, ccr_out, res,
               exp_v[14], exp_v[13:8], exp_v[7:0]);
    end
  endtask

  int mlist [12] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80,
                     8'h81, 8'hF0, 8'hFF, 8'h55, 8'hAA, 8'h3C};

  initial begin
    op = 5'd31; a = 8'h5A; m = 8'h00; ccr_in = 6'h2D;
    repeat (4) @(posedge clk);
    // reset-phase check: undefined code passes everything (R12)
    #1;
    checks++;
    if (wr !== 1'b0 || ccr_out !== 6'h2D || res !== 8'h5A) begin
      fails++;
      $display("FAIL R12 reset idle: got wr=%0b ccr=%02h res=%02h, expected wr=0 ccr=2d res=5a",
               wr, ccr_out, res);
    end
    rst_n = 1'b1;
    // directed corners: R8 inc/dec limits, R7 negate of 0x80, R2 carried borrow
    apply_check(13, 0, 8'h7F, 6'h00);   // R8
    apply_check(14, 0, 8'h80, 6'h01);   // R8
    apply_check(12, 0, 8'h80, 6'h10);   // R7
    apply_check(3, 8'h00, 8'h00, 6'h01); // R2
    apply_check(1, 8'h7F, 8'h00, 6'h01); // R1
    // sweep all codes, all accumulators, boundary operands
    for (int o = 0; o < 32; o++)
      for (int av = 0; av < 256; av++)
        for (int k = 0; k < 12; k++)
          apply_check(o, av, mlist[k], 6'((av * 7 + k * 13 + o * 3) % 64));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule